// File: doc/BRIEF.md
# Self-Correcting Linear Clock/Data Phase Detector

This block is a cycle-level digital model of a linear clock/data phase detector of the retime-and-compare kind. A fast oversampling clock runs it. Two sampled inputs arrive on that clock: a serial NRZ data stream and a recovered bit clock. On each sample where the recovered clock is first seen high, the block retimes the data into a first stage. On each sample where the clock is first seen low, it copies the first stage into a second stage.

Two pulses come from these stages. The up pulse is the data XOR the first stage. Its width is the time from a data transition to the next clock rise, so it carries the phase error. The down pulse is the first stage XOR the second stage. Its width is always half a clock period, so it acts as a fixed reference that cancels the offset which would otherwise depend on transition density. A saturating signed integrator counts up-pulse cycles minus down-pulse cycles. Its value stands in for the averaged control voltage of a clock recovery loop. The retimed data is also brought out.

A two-state tracker follows the sampled clock. Its states are CK_LOW and CK_HIGH. The RISE transition (CK_LOW to CK_HIGH) marks a rising sample, and the FALL transition (CK_HIGH to CK_LOW) marks a falling sample. The integrator picks one of three steps per cycle: STEP_UP, STEP_DN or STEP_HOLD.

Top module: `xor_phase_det`

## Requirements
- R1: `retimed` takes the value `din` had in a cycle where `rck` is sampled high after having been low (a RISE cycle), visible the next cycle. In every other cycle it holds its value.
- R2: `up_pulse` is high exactly while `din` differs from `retimed`. A `din` transition first seen in cycle td keeps `up_pulse` high from td through the first RISE cycle t0 ≥ td, inclusive.
- R3: The second stage copies `retimed` in each FALL cycle, the cycle where `rck` is first sampled low. `dn_pulse` is high while the two stages differ, so after a transition it is high from t0+1 through the next FALL cycle. For a clock held H cycles high and H cycles low, that is exactly H cycles.
- R4: With a recovered clock of period 2H (rising sample at phase 0), the net integrator change per isolated transition is (t0 − td + 1) − H. It is zero when the transition is first seen one cycle after the FALL cycle. It is negative when the data transitions later than that (early clock) and positive when earlier (late clock), and it grows in size by one per cycle of offset. This holds whatever the transition density.
- R5: While `din` does not change and earlier pulses have ended, neither pulse is high and `acc` does not change.
- R6: `acc` steps by +1 in a cycle with only `up_pulse` high (STEP_UP) and by −1 with only `dn_pulse` high (STEP_DN). It holds otherwise (STEP_HOLD). The change is visible in the following cycle.
- R7: `acc` saturates at +2^(ACC_W−1)−1 and −2^(ACC_W−1) instead of wrapping.
- R8: A synchronous `rst` clears `retimed`, the second stage and `acc`, and puts the tracker in CK_LOW. A clock sampled high in the first cycle after reset therefore counts as a RISE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast oversampling clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 1 | Sampled serial NRZ data |
| rck | input | 1 | Sampled recovered bit clock |
| up_pulse | output | 1 | Phase-error pulse (data XOR first stage) |
| dn_pulse | output | 1 | Half-period reference pulse (first XOR second stage) |
| retimed | output | 1 | Retimed data (first stage) |
| acc | output | ACC_W | Signed saturating integrator of up minus down cycles |

## Verification
The assertions check the following on every cycle:
- the capture and hold of the retimed data around RISE cycles;
- that the reference pulse clears after each FALL cycle;
- the single-step motion of the integrator, including that it holds at both limits;
- the reset clearing.

Only the bench's scenarios can show properties that build up over many cycles:
- pulse widths that depend on where a transition falls inside the clock period;
- the zero net change when locked, under both alternating and paired data patterns;
- the signed and proportional net for early and late clocks;
- the ripple from the half-period displacement between the two pulses;
- reaching each saturation limit.

// File: rtl/xpd_pkg.sv
package xpd_pkg;

    // Sampled recovered-clock level as seen by the edge tracker
    typedef enum logic {
        CK_LOW  = 1'b0,
        CK_HIGH = 1'b1
    } ck_state_t;

    // Integrator step chosen each fast-clock cycle
    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DN   = 2'd2
    } step_t;

endpackage

// File: rtl/xpd_edge_fsm.sv
module xpd_edge_fsm
    import xpd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic rck,
    output logic rise_evt,
    output logic fall_evt
);

    ck_state_t state_q;
    ck_state_t state_d;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= CK_LOW;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: RISE and FALL transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CK_LOW:  if (rck)  state_d = CK_HIGH;
            CK_HIGH: if (!rck) state_d = CK_LOW;
        endcase
    end

    // Edge event outputs
    always_comb begin
        rise_evt = 1'b0;
        fall_evt = 1'b0;
        unique case (state_q)
            CK_LOW:  rise_evt = rck;
            CK_HIGH: fall_evt = !rck;
        endcase
    end

endmodule

// File: rtl/xpd_retimer.sv
module xpd_retimer (
    input  logic clk,
    input  logic rst,
    input  logic din,
    input  logic rise_evt,
    input  logic fall_evt,
    output logic stage1,
    output logic p_raw,
    output logic r_raw
);

    logic stage2;

    // First stage samples data on the rising clock sample
    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= 1'b0;
        end else if (rise_evt) begin
            stage1 <= din;
        end
    end

    // Second stage samples the first on the falling clock sample
    always_ff @(posedge clk) begin
        if (rst) begin
            stage2 <= 1'b0;
        end else if (fall_evt) begin
            stage2 <= stage1;
        end
    end

    assign p_raw = din ^ stage1;
    assign r_raw = stage1 ^ stage2;

endmodule

// File: rtl/xpd_integrator.sv
module xpd_integrator
    import xpd_pkg::*;
#(
    parameter int ACC_W = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    up,
    input  logic                    dn,
    output logic signed [ACC_W-1:0] acc
);

    localparam logic signed [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic signed [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};
    localparam logic signed [ACC_W-1:0] ONE     = {{(ACC_W-1){1'b0}}, 1'b1};

    step_t step;

    // Step decode
    always_comb begin
        unique case ({up, dn})
            2'b10:   step = STEP_UP;
            2'b01:   step = STEP_DN;
            default: step = STEP_HOLD;
        endcase
    end

    // Saturating accumulator
    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
        end else begin
            unique case (step)
                STEP_UP:   if (acc != ACC_MAX) acc <= acc + ONE;
                STEP_DN:   if (acc != ACC_MIN) acc <= acc - ONE;
                STEP_HOLD: acc <= acc;
                default:   acc <= acc;
            endcase
        end
    end

endmodule

// File: rtl/xor_phase_det.sv
module xor_phase_det #(
    parameter int ACC_W = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    din,
    input  logic                    rck,
    output logic                    up_pulse,
    output logic                    dn_pulse,
    output logic                    retimed,
    output logic signed [ACC_W-1:0] acc
);

    logic edge_rise;
    logic edge_fall;

    xpd_edge_fsm u_edge (
        .clk      (clk),
        .rst      (rst),
        .rck      (rck),
        .rise_evt (edge_rise),
        .fall_evt (edge_fall)
    );

    xpd_retimer u_retime (
        .clk      (clk),
        .rst      (rst),
        .din      (din),
        .rise_evt (edge_rise),
        .fall_evt (edge_fall),
        .stage1   (retimed),
        .p_raw    (up_pulse),
        .r_raw    (dn_pulse)
    );

    xpd_integrator #(
        .ACC_W (ACC_W)
    ) u_integ (
        .clk (clk),
        .rst (rst),
        .up  (up_pulse),
        .dn  (dn_pulse),
        .acc (acc)
    );

endmodule

// File: rtl/xor_phase_det_chk.sv
module xor_phase_det_chk #(
    parameter int ACC_W = 16
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    din,
    input logic                    rise_evt,
    input logic                    fall_evt,
    input logic                    up_pulse,
    input logic                    dn_pulse,
    input logic                    retimed,
    input logic signed [ACC_W-1:0] acc
);

    localparam logic signed [ACC_W-1:0] C_MAX = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic signed [ACC_W-1:0] C_MIN = {1'b1, {(ACC_W-1){1'b0}}};
    localparam logic signed [ACC_W-1:0] C_ONE = {{(ACC_W-1){1'b0}}, 1'b1};

    a_r1_capture: assert property (@(posedge clk) disable iff (rst)
        rise_evt |=> (retimed == $past(din)));

    a_r1_hold: assert property (@(posedge clk) disable iff (rst)
        !rise_evt |=> $stable(retimed));

    a_r2_after_rise: assert property (@(posedge clk) disable iff (rst)
        rise_evt |=> (up_pulse == (din != $past(din))));

    a_r3_dn_clears: assert property (@(posedge clk) disable iff (rst)
        fall_evt |=> !dn_pulse);

    a_r5_hold_idle: assert property (@(posedge clk) disable iff (rst)
        (up_pulse == dn_pulse) |=> $stable(acc));

    a_r6_step_up: assert property (@(posedge clk) disable iff (rst)
        (up_pulse && !dn_pulse && acc != C_MAX) |=> (acc == $past(acc) + C_ONE));

    a_r6_step_dn: assert property (@(posedge clk) disable iff (rst)
        (dn_pulse && !up_pulse && acc != C_MIN) |=> (acc == $past(acc) - C_ONE));

    a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (acc == C_MAX && up_pulse && !dn_pulse) |=> (acc == C_MAX));

    a_r7_no_underflow: assert property (@(posedge clk) disable iff (rst)
        (acc == C_MIN && dn_pulse && !up_pulse) |=> (acc == C_MIN));

    a_r8_reset_clear: assert property (@(posedge clk)
        rst |=> (acc == '0 && !retimed && !dn_pulse));

endmodule

bind xor_phase_det xor_phase_det_chk #(.ACC_W(ACC_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .din      (din),
    .rise_evt (edge_rise),
    .fall_evt (edge_fall),
    .up_pulse (up_pulse),
    .dn_pulse (dn_pulse),
    .retimed  (retimed),
    .acc      (acc)
);

// File: tb/xor_phase_det_bench.sv
module xor_phase_det_bench;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 4;
    localparam int BITC       = 2 * HALF;
    localparam int W          = 8;
    localparam int NCYC       = 2048;
    localparam int AMAX       = (1 << (W - 1)) - 1;
    localparam int AMIN       = -(1 << (W - 1));

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic din = 1'b0;
    logic rck = 1'b0;
    logic up_pulse;
    logic dn_pulse;
    logic retimed;
    logic signed [W-1:0] acc;

    xor_phase_det #(.ACC_W(W)) u_xor_phase_det (
        .clk      (clk),
        .rst      (rst),
        .din      (din),
        .rck      (rck),
        .up_pulse (up_pulse),
        .dn_pulse (dn_pulse),
        .retimed  (retimed),
        .acc      (acc)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    typedef struct {
        int   n;
        logic p;
        logic r;
        logic q;
        int   a;
    } exp_t;

    exp_t sbq[$];

    bit din_s  [NCYC];
    bit rck_s  [NCYC];
    bit chg_en [NCYC];
    bit chg_val[NCYC];
    bit ep     [NCYC];
    bit er     [NCYC];
    int acc_obs[NCYC];

    int seg_s[8];
    int seg_e[8];
    int seg_tr[8];
    int seg_d[8];
    int nseg = 0;
    int bidx = 0;
    bit curv = 1'b0;
    int nused = 0;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic int sat(input int v);
        if (v > AMAX) return AMAX;
        if (v < AMIN) return AMIN;
        return v;
    endfunction

    // mode 0: hold, 1: alternate every bit, 2: pairs (0011...)
    task automatic add_seg(input int nbits, input int d, input int mode);
        bit s0;
        s0 = curv;
        seg_s[nseg]  = bidx * BITC;
        seg_tr[nseg] = 0;
        seg_d[nseg]  = d;
        for (int j = 0; j < nbits + 2; j++) begin
            bit v;
            if (j >= nbits || mode == 0) v = curv;
            else if (mode == 1)          v = ~curv;
            else                         v = s0 ^ bit'(((j + 2) / 2) % 2);
            if (v != curv) begin
                int td;
                td = bidx * BITC + HALF + d;
                chg_en[td]  = 1'b1;
                chg_val[td] = v;
                seg_tr[nseg]++;
                curv = v;
            end
            bidx++;
        end
        seg_e[nseg] = bidx * BITC;
        nseg++;
    endtask

    task automatic build_plan();
        bit cur;
        add_seg(4,   0, 0);   // 0: idle
        add_seg(16,  1, 1);   // 1: locked, alternating
        add_seg(16,  1, 2);   // 2: locked, paired
        add_seg(12,  3, 1);   // 3: early clock
        add_seg(8,  -2, 1);   // 4: late clock
        add_seg(60, -2, 1);   // 5: late, to upper limit
        add_seg(100, 4, 1);   // 6: early, to lower limit
        add_seg(4,   0, 0);   // 7: idle
        nused = bidx * BITC;
        cur = 1'b0;
        for (int n = 0; n < NCYC; n++) begin
            if (chg_en[n]) cur = chg_val[n];
            din_s[n] = cur;
            rck_s[n] = (n % BITC) < HALF;
        end
        for (int n = 0; n < NCYC; n++) begin
            if (chg_en[n]) begin
                int t0;
                t0 = ((n + BITC - 1) / BITC) * BITC;
                for (int k = n; k <= t0 && k < NCYC; k++) ep[k] = 1'b1;
                for (int k = t0 + 1; k <= t0 + HALF && k < NCYC; k++) er[k] = 1'b1;
            end
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // Monitor: pops expected items and compares
    initial begin
        forever begin
            @(negedge clk);
            #3;
            if (sbq.size() > 0) begin
                exp_t e;
                e = sbq.pop_front();
                acc_obs[e.n] = int'(acc);
                check(up_pulse === e.p, "R2 up_pulse", int'(up_pulse), int'(e.p));
                check(dn_pulse === e.r, "R3 dn_pulse", int'(dn_pulse), int'(e.r));
                check(retimed  === e.q, "R1 retimed",  int'(retimed),  int'(e.q));
                check(int'(acc) == e.a, "R6 acc",      int'(acc),      e.a);
            end
        end
    end

    // Driver
    initial begin
        int accm;
        build_plan();
        rst = 1'b1;
        din = 1'b0;
        rck = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        check(acc == '0,     "R8 reset acc",     int'(acc),      0);
        check(retimed == 0,  "R8 reset retimed", int'(retimed),  0);
        check(dn_pulse == 0, "R8 reset dn",      int'(dn_pulse), 0);
        accm = 0;
        for (int n = 0; n < nused; n++) begin
            exp_t e;
            @(negedge clk);
            rst = 1'b0;
            din = din_s[n];
            rck = rck_s[n];
            e.n = n;
            e.p = ep[n];
            e.r = er[n];
            e.q = (n == 0) ? 1'b0 : din_s[((n - 1) / BITC) * BITC];
            e.a = accm;
            sbq.push_back(e);
            accm = sat(accm + int'(ep[n]) - int'(er[n]));
        end
        @(negedge clk);
        #5;

        // R5: idle spans leave the integrator unchanged
        check(acc_obs[seg_e[0] - 1] == acc_obs[seg_s[0]], "R5 idle start",
              acc_obs[seg_e[0] - 1], acc_obs[seg_s[0]]);
        check(acc_obs[seg_e[7] - 1] == acc_obs[seg_s[7]], "R5 idle end",
              acc_obs[seg_e[7] - 1], acc_obs[seg_s[7]]);
        // R4: locked clock gives zero net, for two densities
        check(acc_obs[seg_e[1] - 1] - acc_obs[seg_s[1]] == 0, "R4 locked alt",
              acc_obs[seg_e[1] - 1] - acc_obs[seg_s[1]], 0);
        check(acc_obs[seg_e[2] - 1] - acc_obs[seg_s[2]] == 0, "R4 locked pairs",
              acc_obs[seg_e[2] - 1] - acc_obs[seg_s[2]], 0);
        // R4: early and late clock, net (1-d) per transition
        for (int s = 3; s <= 4; s++) begin
            int dlt;
            dlt = acc_obs[seg_e[s] - 1] - acc_obs[seg_s[s]];
            check(dlt == seg_tr[s] * (1 - seg_d[s]), "R4 early/late net", dlt, seg_tr[s] * (1 - seg_d[s]));
        end
        // R7: limits reached and never passed
        begin
            int mx;
            int mn;
            mx = AMIN;
            mn = AMAX;
            for (int n = seg_s[5]; n < seg_e[5]; n++) if (acc_obs[n] > mx) mx = acc_obs[n];
            for (int n = seg_s[6]; n < seg_e[6]; n++) if (acc_obs[n] < mn) mn = acc_obs[n];
            check(mx == AMAX, "R7 upper limit", mx, AMAX);
            check(mn == AMIN, "R7 lower limit", mn, AMIN);
        end

        // R8: reset mid-run from a saturated state
        @(negedge clk);
        din = 1'b1;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        #1;
        check(acc == '0,     "R8 clear acc",     int'(acc),      0);
        check(retimed == 0,  "R8 clear retimed", int'(retimed),  0);
        check(dn_pulse == 0, "R8 clear stage2",  int'(dn_pulse), 0);
        check(up_pulse == 1, "R2 din vs cleared", int'(up_pulse), 1);

        done = 1'b1;
        summary();
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R1 watchdog actual=%0d expected=%0d", 0, 1);
            summary();
            $finish;
        end
    end

endmodule